// File: doc/BRIEF.md
# RAM Address and Data Scrambler

This block sits on the path between the processor's memory bus and a single-port word RAM. It hides where data lands in the array and what the stored bits look like. Each word address from the processor is XORed with a 32-bit address key. The result is then cut down to the RAM's word-index width.

Write data is XORed with a 32-bit data key and also with the full processor address. The same value stored at two addresses therefore leaves two different bit patterns in the array. Read data that comes back from the RAM one cycle later goes through the same two XOR operations. It uses the data key and the address that were in force when the read was issued.

Both keys are written through a small configuration port. That port takes effect only while the system is in firmware mode. Firmware normally fills the RAM under one pair of keys and then installs a fresh pair before it loads an application. After a rekey, earlier contents read back as garbled words.

Top module: `ram_scrambler`

## Requirements
- R1: During a request, `ram_idx` equals bits [16:2] of (`cpu_addr` XOR address key). The RAM holds 32768 words (128 KiB), so the index is 15 bits wide.
- R2: During a write request, `ram_wdata` equals `cpu_wdata` XOR data key XOR `cpu_addr`. Equal data at two different addresses gives different `ram_wdata`.
- R3: In the cycle after a read request, `cpu_rdata` equals `ram_rdata` XOR the data key and `cpu_addr` that were present at the read request.
- R4: A word written and then read back at the same address under unchanged keys returns the written value.
- R5: A key write (`cfg_we`=1) while `fw_mode`=0 is ignored, and later accesses still use the old keys. `cfg_sel`=0 selects the address key and `cfg_sel`=1 selects the data key.
- R6: After reset both keys are zero. Until the first key write, `ram_idx` equals `cpu_addr`[16:2] and `ram_wdata` equals `cpu_wdata` XOR `cpu_addr`.
- R7: `ram_en`, `ram_we` and `ram_be` follow `cpu_req`, `cpu_we` and `cpu_be` in the same cycle, with byte enables passed unchanged.
- R8: After firmware rewrites both keys, a read of a previously written address does not return the earlier value. It returns the RAM word now selected, descrambled with the new data key.
- R9: Address key bits [1:0] do not affect `ram_idx`, so byte-lane alignment is preserved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fw_mode | input | 1 | 1 while the system runs firmware; key writes are accepted only then |
| cfg_we | input | 1 | Key write strobe |
| cfg_sel | input | 1 | Key select: 0 address key, 1 data key |
| cfg_wdata | input | 32 | New key value |
| cpu_req | input | 1 | Processor RAM access request |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_be | input | 4 | Byte enables |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Descrambled read data, valid the cycle after a read request |
| ram_en | output | 1 | RAM enable |
| ram_we | output | 1 | RAM write enable |
| ram_be | output | 4 | RAM byte enables |
| ram_idx | output | 15 | RAM word index |
| ram_wdata | output | 32 | Scrambled write data |
| ram_rdata | input | 32 | Raw RAM read data, one cycle after the request |

## Verification
The hardest case to reach is a read whose raw RAM word was stored under a different pair of keys than the pair used to read it. The bench gets there in three steps. It fills a region under one firmware key pair, then installs a second pair, then reads the old addresses back. It predicts the garbled result from its own RAM model. Application-mode key writes are placed between ordinary accesses, so their lack of effect shows up in the next access's index and data.

// File: rtl/ram_scr_pkg.sv
package ram_scr_pkg;

  typedef enum logic {
    KEY_ADDR = 1'b0,
    KEY_DATA = 1'b1
  } key_sel_e;

  function automatic int unsigned idx_width(input int unsigned bytes_total,
                                            input int unsigned word_w);
    return $clog2(bytes_total / (word_w / 8));
  endfunction

endpackage

// File: rtl/ram_scr_rst_sync.sv
module ram_scr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ram_scr_keys.sv
module ram_scr_keys
  import ram_scr_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_mode,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] akey_o,
  output logic [WORD_W-1:0] dkey_o
);

  logic [WORD_W-1:0] akey_q, akey_d;
  logic [WORD_W-1:0] dkey_q, dkey_d;
  logic              akey_en, dkey_en;
  key_sel_e          sel;

  always_comb begin
    sel     = key_sel_e'(cfg_sel);
    akey_en = fw_mode && cfg_we && (sel == KEY_ADDR);
    dkey_en = fw_mode && cfg_we && (sel == KEY_DATA);
    akey_d  = cfg_wdata;
    dkey_d  = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      akey_q <= '0;
    end else if (akey_en) begin
      akey_q <= akey_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dkey_q <= '0;
    end else if (dkey_en) begin
      dkey_q <= dkey_d;
    end
  end

  assign akey_o = akey_q;
  assign dkey_o = dkey_q;

endmodule

// File: rtl/ram_scr_remap.sv
module ram_scr_remap #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 15
) (
  input  logic [WORD_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] akey,
  output logic [IDX_W-1:0]  ram_idx
);

  localparam int unsigned OFF_W = $clog2(WORD_W / 8);

  logic [WORD_W-1:0] mixed;

  always_comb begin
    mixed   = cpu_addr ^ akey;
    ram_idx = mixed[OFF_W +: IDX_W];
  end

endmodule

// File: rtl/ram_scr_datapath.sv
module ram_scr_datapath #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic [WORD_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] dkey,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] ram_wdata,
  input  logic [WORD_W-1:0] ram_rdata,
  output logic [WORD_W-1:0] cpu_rdata
);

  localparam int unsigned LANES = WORD_W / 8;

  logic [WORD_W-1:0] wr_mask;
  logic [WORD_W-1:0] rd_mask_q, rd_mask_d;

  always_comb begin
    wr_mask   = dkey ^ cpu_addr;
    rd_mask_d = wr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_mask_q <= '0;
    end else if (rd_issue) begin
      rd_mask_q <= rd_mask_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      ram_wdata[g*8 +: 8] = cpu_wdata[g*8 +: 8] ^ wr_mask[g*8 +: 8];
      cpu_rdata[g*8 +: 8] = ram_rdata[g*8 +: 8] ^ rd_mask_q[g*8 +: 8];
    end
  end

endmodule

// File: rtl/ram_scrambler.sv
module ram_scrambler
  import ram_scr_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned RAM_BYTES = 131072,
  parameter int unsigned IDX_W     = idx_width(RAM_BYTES, WORD_W),
  parameter int unsigned BE_W      = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_mode,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [BE_W-1:0]   cpu_be,
  input  logic [WORD_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [BE_W-1:0]   ram_be,
  output logic [IDX_W-1:0]  ram_idx,
  output logic [WORD_W-1:0] ram_wdata,
  input  logic [WORD_W-1:0] ram_rdata
);

  logic              rst_n_s;
  logic [WORD_W-1:0] akey_q;
  logic [WORD_W-1:0] dkey_q;
  logic              rd_issue;

  ram_scr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ram_scr_keys #(.WORD_W(WORD_W)) u_keys (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .fw_mode   (fw_mode),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .akey_o    (akey_q),
    .dkey_o    (dkey_q)
  );

  ram_scr_remap #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_remap (
    .cpu_addr (cpu_addr),
    .akey     (akey_q),
    .ram_idx  (ram_idx)
  );

  always_comb begin
    rd_issue = cpu_req && !cpu_we;
    ram_en   = cpu_req;
    ram_we   = cpu_req && cpu_we;
    ram_be   = cpu_be;
  end

  ram_scr_datapath #(.WORD_W(WORD_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rd_issue  (rd_issue),
    .cpu_addr  (cpu_addr),
    .dkey      (dkey_q),
    .cpu_wdata (cpu_wdata),
    .ram_wdata (ram_wdata),
    .ram_rdata (ram_rdata),
    .cpu_rdata (cpu_rdata)
  );

endmodule

// File: rtl/ram_scrambler_chk.sv
module ram_scrambler_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 15
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              fw_mode,
  input logic              cfg_we,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [WORD_W-1:0] cpu_addr,
  input logic [WORD_W-1:0] cpu_wdata,
  input logic [WORD_W-1:0] cpu_rdata,
  input logic [IDX_W-1:0]  ram_idx,
  input logic [WORD_W-1:0] ram_wdata,
  input logic [WORD_W-1:0] ram_rdata,
  input logic [WORD_W-1:0] akey,
  input logic [WORD_W-1:0] dkey
);

  localparam int unsigned OFF_W = $clog2(WORD_W / 8);

  logic keyed_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      keyed_q <= 1'b0;
    end else if (fw_mode && cfg_we) begin
      keyed_q <= 1'b1;
    end
  end

  // R5: key writes outside firmware mode leave both keys untouched
  p_app_lock_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !fw_mode |=> ($stable(akey) && $stable(dkey)));

  // R6: before any accepted key write the mapping is the identity
  p_ident_idx_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!keyed_q && cpu_req) |-> (ram_idx == cpu_addr[OFF_W +: IDX_W]));

  p_ident_data_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!keyed_q && cpu_req && cpu_we) |-> (ram_wdata == (cpu_wdata ^ cpu_addr)));

  // R3: returned word is unmasked with the key and address of the issuing cycle
  p_rd_unmask_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_req && !cpu_we) |=>
      (cpu_rdata == (ram_rdata ^ $past(dkey) ^ $past(cpu_addr))));

  // R2: the difference between RAM data and CPU data is the key plus address
  p_wr_mask_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_req && cpu_we) |-> ((ram_wdata ^ cpu_wdata ^ cpu_addr) == dkey));

endmodule

bind ram_scrambler ram_scrambler_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .fw_mode   (fw_mode),
  .cfg_we    (cfg_we),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_rdata (cpu_rdata),
  .ram_idx   (ram_idx),
  .ram_wdata (ram_wdata),
  .ram_rdata (ram_rdata),
  .akey      (akey_q),
  .dkey      (dkey_q)
);

// File: tb/ram_scrambler_tb_top.sv
module ram_scrambler_tb_top;

  localparam int unsigned NV = 6;
  localparam logic [63:0] VEC [NV] = '{
    {32'h4000_0000, 32'h1234_5678},
    {32'h4000_0004, 32'h1234_5678},
    {32'h4000_0010, 32'hdead_beef},
    {32'h4000_0024, 32'h0000_0000},
    {32'h4000_0038, 32'hffff_ffff},
    {32'h4000_03fc, 32'ha5a5_5a5a}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fw_mode, cfg_we, cfg_sel;
  logic [31:0] cfg_wdata;
  logic        cpu_req, cpu_we;
  logic [3:0]  cpu_be;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        ram_en, ram_we;
  logic [3:0]  ram_be;
  logic [14:0] ram_idx;
  logic [31:0] ram_wdata, ram_rdata;

  logic [31:0] mem [256];
  logic [31:0] ak, dk;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  ram_scrambler dut_i (
    .clk(clk), .rst_n(rst_n), .fw_mode(fw_mode), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cpu_req(cpu_req),
    .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ram_en(ram_en),
    .ram_we(ram_we), .ram_be(ram_be), .ram_idx(ram_idx),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) begin
        for (int b = 0; b < 4; b++)
          if (ram_be[b]) mem[ram_idx[7:0]][b*8 +: 8] <= ram_wdata[b*8 +: 8];
      end
      ram_rdata <= mem[ram_idx[7:0]];
    end
  end

  function automatic logic [14:0] exp_idx(input logic [31:0] a, input logic [31:0] k);
    logic [31:0] m;
    m = a ^ k;
    return m[16:2];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_key(input bit sel, input logic [31:0] v, input bit fw);
    @(negedge clk);
    fw_mode = fw; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; fw_mode = 1'b1;
    if (fw) begin
      if (sel) dk = v; else ak = v;
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] be, input string tag);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_be = be; cpu_addr = a; cpu_wdata = d;
    #2;
    check(ram_idx == exp_idx(a, ak), {tag, " R1 idx"}, {17'd0, ram_idx}, {17'd0, exp_idx(a, ak)});
    check(ram_wdata == (d ^ dk ^ a), {tag, " R2 wdata"}, ram_wdata, d ^ dk ^ a);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] r,
                         output logic [31:0] raw);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_be = 4'hf; cpu_addr = a;
    raw = mem[exp_idx(a, ak) & 15'hff];
    @(negedge clk);
    cpu_req = 1'b0;
    cpu_addr = 32'h4000_0f00;
    #2;
    r = cpu_rdata;
  endtask

  initial begin
    logic [31:0] r, raw, w0, w1;
    rst_n = 1'b0; fw_mode = 1'b1; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_be = 4'hf; cpu_addr = '0; cpu_wdata = '0;
    ak = '0; dk = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6: identity mapping after reset; R7: idle outputs
    cpu_addr = 32'h4000_1234; cpu_wdata = 32'h0f0f_0f0f;
    #2;
    check(ram_idx == 15'h048d, "R6 reset idx", {17'd0, ram_idx}, 32'h048d);
    check(ram_wdata == 32'h4f0f_1d3b, "R6 reset wdata", ram_wdata, 32'h4f0f_1d3b);
    check(ram_en == 1'b0 && ram_we == 1'b0, "R7 idle en", {30'd0, ram_en, ram_we}, 32'd0);

    // R7: strobes and byte enables pass through
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_be = 4'b0010; cpu_addr = 32'h4000_0080;
    #2;
    check(ram_en && ram_we && ram_be == 4'b0010, "R7 pass", {27'd0, ram_en, ram_we, ram_be},
          {27'd0, 1'b1, 1'b1, 4'b0010});
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_be = 4'hf;

    // program first key pair in firmware mode
    set_key(1'b0, 32'h0000_0a5c, 1'b1);
    set_key(1'b1, 32'h9e37_79b9, 1'b1);

    // R1 R2 R4: table walk, write all then read all back
    for (int i = 0; i < NV; i++) do_write(VEC[i][63:32], VEC[i][31:0], 4'hf, "vec");
    for (int i = 0; i < NV; i++) begin
      do_read(VEC[i][63:32], r, raw);
      check(r == VEC[i][31:0], "R4 roundtrip", r, VEC[i][31:0]);
      check(r == (raw ^ dk ^ VEC[i][63:32]), "R3 unmask", r, raw ^ dk ^ VEC[i][63:32]);
    end

    // R2: same data, different addresses, different stored words
    w0 = VEC[0][31:0] ^ dk ^ VEC[0][63:32];
    w1 = VEC[1][31:0] ^ dk ^ VEC[1][63:32];
    check(w0 != w1, "R2 addr dependence", w0, w1);

    // R5: application-mode key writes are ignored
    set_key(1'b0, 32'h0001_ff00, 1'b0);
    set_key(1'b1, 32'h5555_aaaa, 1'b0);
    do_write(32'h4000_0040, 32'h0bad_f00d, 4'hf, "R5 after app write");
    do_read(32'h4000_0040, r, raw);
    check(r == 32'h0bad_f00d, "R5 keys held", r, 32'h0bad_f00d);

    // R9: low address key bits leave the index alone
    set_key(1'b0, 32'h0000_0a5f, 1'b1);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'h4000_0010;
    #2;
    check(ram_idx == exp_idx(32'h4000_0010, 32'h0000_0a5c), "R9 lane bits",
          {17'd0, ram_idx}, {17'd0, exp_idx(32'h4000_0010, 32'h0000_0a5c)});
    @(negedge clk);
    cpu_req = 1'b0;
    set_key(1'b0, 32'h0000_0a5c, 1'b1);

    // R8: rekey garbles earlier contents
    set_key(1'b0, 32'h0000_0360, 1'b1);
    set_key(1'b1, 32'h0c0f_fee0, 1'b1);
    do_read(VEC[2][63:32], r, raw);
    check(r != VEC[2][31:0], "R8 garbled", r, VEC[2][31:0]);
    check(r == (raw ^ dk ^ VEC[2][63:32]), "R8 new key unmask", r, raw ^ dk ^ VEC[2][63:32]);

    // R4 under the new keys
    do_write(32'h4000_0100, 32'hcafe_0001, 4'hf, "R1 R2 rekeyed");
    do_read(32'h4000_0100, r, raw);
    check(r == 32'hcafe_0001, "R4 rekeyed roundtrip", r, 32'hcafe_0001);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule